// File: doc/BRIEF.md
# Dual-Mode Cartridge Bank Mapper

This block translates CPU and pattern-memory addresses into banked ROM addresses for a game cartridge. It sits on an 8-bit CPU data bus with a 16-bit address and on a 14-bit pattern-memory (PPU) address bus. It drives the banked program ROM address, the banked pattern (CHR) address, the nametable A10 select and a gated interrupt line.

A mode register at one fixed CPU address picks one of two behaviours. In the native mode, the block decodes its own registers:

- two program bank selects;
- eight CHR bank selects, each written a nibble at a time;
- a mirroring control.

In the delegated mode, every other CPU write is forwarded to an external bank-select unit, which is modelled here as ports. That unit supplies the program bank, the 1 KB CHR bank, the mirroring choice and the interrupt request. In this mode the block only ORs an outer CHR bank bit into the unit's CHR bank number, and a separate mode bit controls this for each of three pattern regions.

Top module: `dual_mode_mapper`

## Requirements
- R1: A CPU write to address 0xA131 loads the 8-bit mode register in either mode. Mode bit 1 set (value 0x02) selects delegated mode; clear selects native mode. The write never reaches the external unit.
- R2: After reset the mode register, both program bank registers, all eight CHR registers and the mirroring register are zero, so the block starts in native mode.
- R3: In native mode a write outside 0xB000–0xEFFF is decoded on (address & 0xF003). The value 0x8000 loads program register 0, 0xA000 loads program register 1 and 0x9000 loads the mirroring register. Any other value changes nothing.
- R4: For CPU addresses 0x8000–0xFFFF in native mode, prgRomAddr = {bank, cpuAddr[12:0]}, where bank is picked by cpuAddr[14:13]: 0 gives program register 0 modulo PRG_BANKS, 1 gives program register 1 modulo PRG_BANKS, 2 gives PRG_BANKS−2 and 3 gives PRG_BANKS−1.
- R5: In native mode a write in 0xB000–0xEFFF targets CHR register ((cpuAddr[14:12] − 3) × 2) + cpuAddr[1].
- R6: A CHR register write replaces one nibble with the low nibble of the data. When cpuAddr[0] is 0 it replaces the low nibble; when cpuAddr[0] is 1 it replaces the high nibble. For example, 0x0A to 0xB000 followed by 0x03 to 0xB001 gives 0x3A in register 0.
- R7: In native mode chrAddr = {1'b0, chrReg[ppuAddr[12:10]], ppuAddr[9:0]}.
- R8: When mirroring bit 0 is 0 (vertical), ntA10 follows ppuAddr[10]; when it is 1 (horizontal), ntA10 follows ppuAddr[11]. In delegated mode extMirrorH takes the place of the mirroring bit.
- R9: In delegated mode chrAddr = {outer, extChrBank, ppuAddr[9:0]}. The outer bit is mode bit 3 for ppuAddr 0x0000–0x0FFF, mode bit 5 for 0x1000–0x17FF and mode bit 7 for 0x1800–0x1FFF.
- R10: In delegated mode CPU writes other than to 0xA131 leave all native registers unchanged, and prgRomAddr = {extPrgBank modulo PRG_BANKS, cpuAddr[12:0]}.
- R11: irq is high only while delegated mode is active and extIrq is high.
- R12: extWrite equals cpuWrite while delegated mode is active and cpuAddr is not 0xA131, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes take effect on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWrite | input | 1 | CPU write strobe for the current cycle |
| ppuAddr | input | 14 | Pattern-memory address |
| extPrgBank | input | 8 | Program bank from the external unit for the current CPU address |
| extChrBank | input | 8 | 1 KB CHR bank from the external unit for the current pattern address |
| extMirrorH | input | 1 | Mirroring choice from the external unit, 1 = horizontal |
| extIrq | input | 1 | Interrupt request from the external unit |
| extWrite | output | 1 | Write strobe forwarded to the external unit |
| prgRomAddr | output | PRG_BANK_W+13 | Banked program ROM byte address |
| chrAddr | output | 19 | Banked CHR byte address |
| ntA10 | output | 1 | Nametable A10 select |
| irq | output | 1 | Gated interrupt request |

## Verification
Some rules can be checked on every cycle, and the embedded assertions cover those:

- the decoder raises at most one load strobe, and none in delegated mode;
- a mode write lands on the next edge;
- native registers hold still while delegated mode is active;
- the last program window stays pinned;
- the outer CHR bit stays low when its mode bit is clear;
- irq never rises without both delegated mode and a request.

Other rules need scenarios that only the bench can build. These include the nibble pairing into a full CHR bank, the index arithmetic for each of the eight registers, modulo reduction of out-of-range program banks, native registers surviving a visit to delegated mode, and the choice of mirroring line. The bench checks these against a reference model under random write streams and directed cases.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int CHR_SLOTS = 8;
  localparam int CHR_IDX_W = $clog2(CHR_SLOTS);
  localparam logic [15:0] MODE_ADDR = 16'hA131;

  // Load strobes from the address decoder to the register file
  typedef struct packed {
    logic                 modeLoad;
    logic                 prg0Load;
    logic                 prg1Load;
    logic                 mirrorLoad;
    logic                 chrLoLoad;
    logic                 chrHiLoad;
    logic [CHR_IDX_W-1:0] chrIdx;
  } mapStrobe_t;

endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic        cpuWrite,
  input  logic        altMode,
  output mapStrobe_t  strb,
  output logic        extWrite
);

  logic       isModeAddr;
  logic       inChrRange;
  logic [15:0] maskedAddr;
  logic [2:0] regionMinus;
  logic       localWrite;

  assign isModeAddr  = (cpuAddr == MODE_ADDR);
  assign inChrRange  = (cpuAddr >= 16'hB000) && (cpuAddr <= 16'hEFFF);
  assign maskedAddr  = cpuAddr & 16'hF003;
  assign regionMinus = cpuAddr[14:12] - 3'd3;
  assign localWrite  = cpuWrite && !isModeAddr && !altMode;

  always_comb begin
    strb            = '0;
    strb.modeLoad   = cpuWrite && isModeAddr;
    strb.chrIdx     = {regionMinus[1:0], cpuAddr[1]};
    if (localWrite) begin
      if (inChrRange) begin
        strb.chrLoLoad = !cpuAddr[0];
        strb.chrHiLoad = cpuAddr[0];
      end else begin
        strb.prg0Load   = (maskedAddr == 16'h8000);
        strb.mirrorLoad = (maskedAddr == 16'h9000);
        strb.prg1Load   = (maskedAddr == 16'hA000);
      end
    end
  end

  assign extWrite = cpuWrite && altMode && !isModeAddr;

  // R3: the decoder never raises two loads at once
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.modeLoad, strb.prg0Load, strb.prg1Load,
              strb.mirrorLoad, strb.chrLoLoad, strb.chrHiLoad}));

  // R10: no native register load while delegated
  p_no_local_alt_r10: assert property (@(posedge clk) disable iff (!rstN)
    altMode |-> !(strb.prg0Load || strb.prg1Load || strb.mirrorLoad ||
                  strb.chrLoLoad || strb.chrHiLoad));

  // R12: forwarded write and local loads are exclusive
  p_ext_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    extWrite |-> !(strb.modeLoad || strb.prg0Load || strb.chrLoLoad || strb.chrHiLoad));

endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 12,
  localparam int PRG_BANK_W = $clog2(PRG_BANKS),
  localparam int PRG_ADDR_W = PRG_BANK_W + 13
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  mapStrobe_t            strb,
  input  logic [7:0]            cpuData,
  input  logic [15:0]           cpuAddr,
  input  logic [13:0]           ppuAddr,
  input  logic [7:0]            extPrgBank,
  input  logic [7:0]            extChrBank,
  input  logic                  extMirrorH,
  output logic                  altMode,
  output logic [PRG_ADDR_W-1:0] prgRomAddr,
  output logic [18:0]           chrAddr,
  output logic                  ntA10
);

  localparam logic [PRG_BANK_W-1:0] LAST_BANK = PRG_BANK_W'(PRG_BANKS - 1);
  localparam logic [PRG_BANK_W-1:0] PENULT_BANK = PRG_BANK_W'(PRG_BANKS - 2);

  logic [7:0] modeReg;
  logic [7:0] prgReg0;
  logic [7:0] prgReg1;
  logic [7:0] mirrorReg;
  logic [7:0] chrReg [CHR_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= '0;
      prgReg0   <= '0;
      prgReg1   <= '0;
      mirrorReg <= '0;
    end else begin
      if (strb.modeLoad)   modeReg   <= cpuData;
      if (strb.prg0Load)   prgReg0   <= cpuData;
      if (strb.prg1Load)   prgReg1   <= cpuData;
      if (strb.mirrorLoad) mirrorReg <= cpuData;
    end
  end

  for (genvar g = 0; g < CHR_SLOTS; g++) begin : g_chr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chrReg[g] <= '0;
      end else if (strb.chrIdx == CHR_IDX_W'(g)) begin
        if (strb.chrLoLoad) chrReg[g][3:0] <= cpuData[3:0];
        if (strb.chrHiLoad) chrReg[g][7:4] <= cpuData[3:0];
      end
    end
  end

  assign altMode = modeReg[1];

  // Program window mapping
  logic [7:0]            prgSel;
  logic [PRG_BANK_W-1:0] prgBank;

  always_comb begin
    prgSel  = altMode ? extPrgBank : (cpuAddr[13] ? prgReg1 : prgReg0);
    prgBank = PRG_BANK_W'(32'(prgSel) % PRG_BANKS);
    if (!altMode && cpuAddr[14])
      prgBank = cpuAddr[13] ? LAST_BANK : PENULT_BANK;
  end

  assign prgRomAddr = {prgBank, cpuAddr[12:0]};

  // Pattern mapping with per-region outer bit
  logic outerBit;
  always_comb begin
    if (!ppuAddr[12])      outerBit = modeReg[3];
    else if (!ppuAddr[11]) outerBit = modeReg[5];
    else                   outerBit = modeReg[7];
  end

  assign chrAddr = altMode ? {outerBit, extChrBank, ppuAddr[9:0]}
                           : {1'b0, chrReg[ppuAddr[12:10]], ppuAddr[9:0]};

  logic mirrorH;
  assign mirrorH = altMode ? extMirrorH : mirrorReg[0];
  assign ntA10   = mirrorH ? ppuAddr[11] : ppuAddr[10];

  // R1: mode write lands on the following edge
  p_mode_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeLoad |=> (modeReg == $past(cpuData)));

  // R10: native registers frozen while delegated
  p_alt_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (altMode && !strb.modeLoad) |=>
      ($stable(prgReg0) && $stable(prgReg1) && $stable(mirrorReg)));

  // R4: top window pinned to the last bank
  p_last_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!altMode && cpuAddr[15:13] == 3'b111) |->
      (prgRomAddr[PRG_ADDR_W-1:13] == LAST_BANK));

  // R9: outer bit low for the low region when mode bit 3 is clear
  p_outer_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (altMode && !modeReg[3] && !ppuAddr[12]) |-> !chrAddr[18]);

endmodule

// File: rtl/dual_mode_mapper.sv
module dual_mode_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 12,
  localparam int PRG_BANK_W = $clog2(PRG_BANKS)
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [15:0]             cpuAddr,
  input  logic [7:0]              cpuData,
  input  logic                    cpuWrite,
  input  logic [13:0]             ppuAddr,
  input  logic [7:0]              extPrgBank,
  input  logic [7:0]              extChrBank,
  input  logic                    extMirrorH,
  input  logic                    extIrq,
  output logic                    extWrite,
  output logic [PRG_BANK_W+12:0]  prgRomAddr,
  output logic [18:0]             chrAddr,
  output logic                    ntA10,
  output logic                    irq
);

  mapStrobe_t strb;
  logic       altMode;

  mapper_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuAddr  (cpuAddr),
    .cpuWrite (cpuWrite),
    .altMode  (altMode),
    .strb     (strb),
    .extWrite (extWrite)
  );

  mapper_datapath #(.PRG_BANKS(PRG_BANKS)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cpuData    (cpuData),
    .cpuAddr    (cpuAddr),
    .ppuAddr    (ppuAddr),
    .extPrgBank (extPrgBank),
    .extChrBank (extChrBank),
    .extMirrorH (extMirrorH),
    .altMode    (altMode),
    .prgRomAddr (prgRomAddr),
    .chrAddr    (chrAddr),
    .ntA10      (ntA10)
  );

  assign irq = altMode && extIrq;

  // R11: interrupt only from the external unit in delegated mode
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (extIrq && altMode));

endmodule

// File: tb/test_dual_mode_mapper.sv
module test_dual_mode_mapper;

  localparam int CLK_PERIOD = 10;
  localparam int PRG_BANKS = 12;
  localparam int PBW = $clog2(PRG_BANKS);

  logic clk = 0;
  logic rstN = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0]  cpuData = 0;
  logic        cpuWrite = 0;
  logic [13:0] ppuAddr = 0;
  logic [7:0]  extPrgBank = 0, extChrBank = 0;
  logic        extMirrorH = 0, extIrq = 0;
  logic        extWrite, ntA10, irq;
  logic [PBW+12:0] prgRomAddr;
  logic [18:0] chrAddr;

  int nRun = 0, nFail = 0;
  bit done = 0;

  logic [7:0] mMode, mPrg0, mPrg1, mMir;
  logic [7:0] mChr [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mode_mapper #(.PRG_BANKS(PRG_BANKS)) i_dual_mode_mapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWrite(cpuWrite), .ppuAddr(ppuAddr), .extPrgBank(extPrgBank),
    .extChrBank(extChrBank), .extMirrorH(extMirrorH), .extIrq(extIrq),
    .extWrite(extWrite), .prgRomAddr(prgRomAddr), .chrAddr(chrAddr),
    .ntA10(ntA10), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expPrg(logic [15:0] a);
    int b;
    if (mMode[1]) b = int'(extPrgBank) % PRG_BANKS;
    else case (a[14:13])
      2'd0: b = int'(mPrg0) % PRG_BANKS;
      2'd1: b = int'(mPrg1) % PRG_BANKS;
      2'd2: b = PRG_BANKS - 2;
      default: b = PRG_BANKS - 1;
    endcase
    return (b << 13) | a[12:0];
  endfunction

  function automatic logic [31:0] expChr(logic [13:0] p);
    logic o;
    if (!mMode[1]) return {13'd0, 1'b0, mChr[p[12:10]], p[9:0]};
    o = !p[12] ? mMode[3] : (!p[11] ? mMode[5] : mMode[7]);
    return {13'd0, o, extChrBank, p[9:0]};
  endfunction

  function automatic logic expNt(logic [13:0] p);
    logic h;
    h = mMode[1] ? extMirrorH : mMir[0];
    return h ? p[11] : p[10];
  endfunction

  task automatic modelWrite(logic [15:0] a, logic [7:0] d);
    logic [15:0] m;
    logic [2:0] r;
    int idx;
    if (a == 16'hA131) begin mMode = d; return; end
    if (mMode[1]) return;
    if (a >= 16'hB000 && a <= 16'hEFFF) begin
      r = a[14:12] - 3'd3;
      idx = int'({r[1:0], a[1]});
      if (!a[0]) mChr[idx][3:0] = d[3:0];
      else       mChr[idx][7:4] = d[3:0];
    end else begin
      m = a & 16'hF003;
      if (m == 16'h8000) mPrg0 = d;
      else if (m == 16'h9000) mMir = d;
      else if (m == 16'hA000) mPrg1 = d;
    end
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWrite = 1;
    #1;
    chk("R12 extWrite", 32'(extWrite), 32'(mMode[1] && a != 16'hA131));
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    cpuWrite = 0;
  endtask

  task automatic probe(string tag, logic [15:0] a, logic [13:0] p);
    cpuAddr = a; ppuAddr = p;
    #1;
    chk({tag, " prg"}, 32'(prgRomAddr), expPrg(a));
    chk({tag, " chr"}, 32'(chrAddr), expChr(p));
    chk({tag, " nt R8"}, 32'(ntA10), 32'(expNt(p)));
    chk("R11 irq", 32'(irq), 32'(mMode[1] && extIrq));
  endtask

  task automatic randProbe(string tag);
    @(negedge clk);
    extPrgBank = 8'($urandom); extChrBank = 8'($urandom);
    extMirrorH = 1'($urandom); extIrq = 1'($urandom);
    probe(tag, 16'h8000 | 16'($urandom), 14'($urandom) & 14'h1FFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd1234));
    mMode = 0; mPrg0 = 0; mPrg1 = 0; mMir = 0;
    for (int i = 0; i < 8; i++) mChr[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R2 reset state
    extIrq = 1;
    @(negedge clk);
    probe("R2 reset", 16'h8123, 14'h0456);
    chk("R2 reset window1", 32'(prgRomAddr[PBW+12:13]), 0);
    probe("R2 reset chr", 16'hA000, 14'h1C00);

    // R6 nibble pairing, R5 index 0
    busWrite(16'hB000, 8'h0A);
    busWrite(16'hB001, 8'h03);
    @(negedge clk);
    probe("R6 nibble", 16'h8000, 14'h0000);
    chk("R6 bank 0x3A", 32'(chrAddr[17:10]), 32'h3A);

    // R5 each register index
    for (int k = 0; k < 8; k++) begin
      a = 16'hB000 + 16'((k >> 1) << 12) + 16'((k & 1) << 1);
      busWrite(a, 8'(k + 1));
      busWrite(a | 16'h0001, 8'(k + 8));
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      probe("R5 R7 chr reg", 16'h8000, 14'(k << 10) | 14'h0155);
    end

    // R3/R4 program regs and modulo
    busWrite(16'h8000, 8'd13);
    busWrite(16'hA000, 8'd250);
    busWrite(16'h8001, 8'd7);
    busWrite(16'hF000, 8'd7);
    @(negedge clk);
    probe("R4 mod w0", 16'h8abc, 14'h0);
    chk("R4 13 mod 12", 32'(prgRomAddr[PBW+12:13]), 1);
    probe("R4 w1", 16'hA001, 14'h0);
    probe("R4 w2", 16'hC777, 14'h0);
    probe("R4 w3", 16'hFFFF, 14'h0);
    probe("R3 ignored", 16'h8000, 14'h0);

    // R8 mirroring
    busWrite(16'h9000, 8'h01);
    @(negedge clk);
    probe("R8 horiz", 16'h8000, 14'h0800);
    probe("R8 horiz2", 16'h8000, 14'h0400);
    busWrite(16'h9000, 8'h00);
    @(negedge clk);
    probe("R8 vert", 16'h8000, 14'h0400);

    // R1/R9 delegated mode with outer bits
    busWrite(16'hA131, 8'h0A);
    extChrBank = 8'h04;
    @(negedge clk);
    probe("R9 low outer", 16'h8000, 14'h0000);
    chk("R9 bank 0x104", 32'(chrAddr[18:10]), 32'h104);
    probe("R9 mid clear", 16'h8000, 14'h1000);
    busWrite(16'hA131, 8'hA2);
    @(negedge clk);
    probe("R9 mid", 16'h8000, 14'h1200);
    probe("R9 high", 16'h8000, 14'h1C00);
    probe("R1 R10 prg", 16'h9000, 14'h0);

    // R10 native regs untouched by delegated writes
    busWrite(16'h8000, 8'h05);
    busWrite(16'hB000, 8'h0F);
    busWrite(16'h9000, 8'h01);
    busWrite(16'hA131, 8'h00);
    @(negedge clk);
    probe("R10 held prg0", 16'h8000, 14'h0000);
    probe("R10 held mirror", 16'h8000, 14'h0400);

    // Random mixed stream
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 6)
        0: a = 16'hA131;
        1: a = 16'hB000 | 16'($urandom % 16'h4000);
        default: a = 16'h8000 | 16'($urandom);
      endcase
      busWrite(a, 8'($urandom));
      randProbe("R4 R7 R9 R10 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule